// File: doc/BRIEF.md
# Power-Good Frequency Select Latch

This block holds the frequency-select strapping of a clock generator. Four two-level select inputs and one three-level select input are sampled once, when an active-low power-good input is first seen low and stable. After that the captured code stays fixed for the downstream dividers, whatever the straps or power-good do later. The three-level input arrives already decoded into a two-bit level: low, mid or high.

When the three-level input is high at capture, the block enters test mode. In test mode one of the two-level selects chooses what the clock outputs do: float, or carry the reference clock divided down. In test mode the one-shot lock is released. While power-good stays low the code follows the straps on every cycle. A deassertion of power-good drops the block back to its waiting state, and the next valid low captures again. Until the first capture the block reports not-ready and drives a fixed default code. An asynchronous reset clears the lock.

Top module: `fsel_latch`

## Requirements
- R1: While reset is held, and at any time before a capture, `ready` is 0, `testMode` is 0, `testDivRef` is 0 and `selCode` equals the default code. The default code has level bits `selCode[5:4]` = 2'b01 (mid) and select bits `selCode[3:0]` = `DEFAULT_SEL`, which is 0 by default.
- R2: `pwrOkN` passes through a two-flop synchronizer, and a capture needs two consecutive synchronized low samples. After `pwrOkN` falls and stays low, `ready` rises and `selCode` = {`midLvl`, `selBin`} on the fourth rising clock edge, and not before it.
- R3: A low on `pwrOkN` seen by only one rising edge causes no capture.
- R4: Once captured outside test mode, later changes on `selBin` and `midLvl` leave `selCode`, `testMode` and `testDivRef` unchanged.
- R5: Once captured outside test mode, deasserting and reasserting `pwrOkN` leaves all outputs unchanged.
- R6: `testMode` is 1 after a capture whose level is high (`midLvl[1]` = 1, codes 2'b10 or 2'b11). It is 0 after a capture whose level is low (2'b00) or mid (2'b01).
- R7: In test mode `testDivRef` equals the captured `selBin[1]`: 1 means outputs carry the divided reference, 0 means outputs tristate. Outside test mode `testDivRef` is 0.
- R8: In test mode, while `pwrOkN` stays low, the code is recaptured on every rising edge, so a strap change shows on the next edge. A recapture with a non-high level leaves test mode and locks.
- R9: In test mode, a high on `pwrOkN` returns the block to the not-ready default state on the third rising edge after the input rises. A later valid low captures again.
- R10: An asserted `rstN` (low, asynchronous) clears the lock, so a capture after reset takes the straps present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrOkN | input | 1 | Power-good, active low, asynchronous to clk |
| selBin | input | 4 | Two-level select straps |
| midLvl | input | 2 | Decoded three-level strap: 00 low, 01 mid, 1x high |
| selCode | output | 6 | Latched code {level, straps} |
| ready | output | 1 | A capture has taken place |
| testMode | output | 1 | Test mode is active |
| testDivRef | output | 1 | Test behaviour: 1 divided reference, 0 tristate |

## Verification
The assertions watch on every cycle that the outputs sit at the default whenever the block is not ready. They also check that a locked non-test code never moves, that the test flag and behaviour selector agree with the captured code, and that `ready` never rises without two earlier low samples of power-good. Only the bench scenarios can show the exact four-edge capture latency, that a single-edge glitch is rejected, that test-mode recapture and release happen, and that an asynchronous reset lets different straps be taken.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_MID = 2'b01;

  typedef enum logic [1:0] {ST_WAIT, ST_LOCK, ST_TEST} fselState_t;

  typedef struct packed {
    logic capture;
    logic restore;
  } fselStrobe_t;
endpackage

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrOkN,
  input  logic        midHighIn,
  output fselStrobe_t stb,
  output logic        ready
);
  localparam int HIST_W = CONFIRM - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [HIST_W-1:0]      histQ;
  logic                   syncOut;
  logic                   validLow;
  fselState_t             state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pwrOkN};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) histQ <= '1;
        else       histQ <= syncOut;
      end
    end else begin : g_histN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) histQ <= '1;
        else       histQ <= {histQ[HIST_W-2:0], syncOut};
      end
    end
  endgenerate

  assign validLow = !syncOut && (histQ == '0);

  always_comb begin
    stateNext   = state;
    stb.capture = 1'b0;
    stb.restore = 1'b0;
    case (state)
      ST_WAIT: begin
        if (validLow) begin
          stb.capture = 1'b1;
          stateNext   = midHighIn ? ST_TEST : ST_LOCK;
        end
      end
      ST_LOCK: stateNext = ST_LOCK;
      ST_TEST: begin
        if (syncOut) begin
          stb.restore = 1'b1;
          stateNext   = ST_WAIT;
        end else if (validLow) begin
          stb.capture = 1'b1;
          stateNext   = midHighIn ? ST_TEST : ST_LOCK;
        end
      end
      default: begin
        stb.restore = 1'b1;
        stateNext   = ST_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNext;
  end

  assign ready = (state != ST_WAIT);
endmodule

// File: rtl/fsel_dpath.sv
module fsel_dpath
  import fsel_pkg::*;
#(
  parameter int              SEL_W       = 4,
  parameter logic [SEL_W-1:0] DEFAULT_SEL = '0,
  parameter int              DIVREF_BIT  = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fselStrobe_t            stb,
  input  logic [SEL_W-1:0]       selBin,
  input  logic [LVL_W-1:0]       midLvl,
  output logic [SEL_W+LVL_W-1:0] selCode,
  output logic                   testMode,
  output logic                   testDivRef
);
  localparam int CODE_W = SEL_W + LVL_W;
  localparam logic [CODE_W-1:0] DEFAULT_CODE = {LVL_MID, DEFAULT_SEL};

  logic [CODE_W-1:0] codeQ;
  logic              testQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= DEFAULT_CODE;
      testQ <= 1'b0;
    end else if (stb.restore) begin
      codeQ <= DEFAULT_CODE;
      testQ <= 1'b0;
    end else if (stb.capture) begin
      codeQ <= {midLvl, selBin};
      testQ <= midLvl[LVL_W-1];
    end
  end

  assign selCode    = codeQ;
  assign testMode   = testQ;
  assign testDivRef = testQ & codeQ[DIVREF_BIT];
endmodule

// File: rtl/fsel_latch.sv
module fsel_latch
  import fsel_pkg::*;
#(
  parameter int               SEL_W       = 4,
  parameter logic [SEL_W-1:0] DEFAULT_SEL = '0,
  parameter int               DIVREF_BIT  = 1,
  parameter int               SYNC_STAGES = 2,
  parameter int               CONFIRM     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pwrOkN,
  input  logic [SEL_W-1:0]       selBin,
  input  logic [1:0]             midLvl,
  output logic [SEL_W+1:0]       selCode,
  output logic                   ready,
  output logic                   testMode,
  output logic                   testDivRef
);
  fselStrobe_t stb;

  fsel_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CONFIRM(CONFIRM)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrOkN(pwrOkN),
    .midHighIn(midLvl[1]), .stb(stb), .ready(ready)
  );

  fsel_dpath #(.SEL_W(SEL_W), .DEFAULT_SEL(DEFAULT_SEL), .DIVREF_BIT(DIVREF_BIT)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .selBin(selBin), .midLvl(midLvl),
    .selCode(selCode), .testMode(testMode), .testDivRef(testDivRef)
  );
endmodule

// File: rtl/fsel_latch_chk.sv
module fsel_latch_chk #(
  parameter int               SEL_W       = 4,
  parameter logic [SEL_W-1:0] DEFAULT_SEL = '0,
  parameter int               DIVREF_BIT  = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrOkN,
  input logic [SEL_W+1:0] selCode,
  input logic             ready,
  input logic             testMode,
  input logic             testDivRef
);
  localparam logic [SEL_W+1:0] DEF_CODE = {2'b01, DEFAULT_SEL};

  AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (selCode == DEF_CODE && !testMode && !testDivRef)); // R1

  AST_CAPTURE_NEEDS_TWO_LOWS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (!$past(pwrOkN, 3) && !$past(pwrOkN, 4))); // R2 R3

  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !testMode) |=> (ready && $stable(selCode) && !testMode)); // R4 R5

  AST_TEST_FROM_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (ready && selCode[SEL_W+1])); // R6

  AST_DIVREF_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (testDivRef == selCode[DIVREF_BIT])); // R7

  AST_DIVREF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> !testDivRef); // R7
endmodule

bind fsel_latch fsel_latch_chk #(.SEL_W(SEL_W), .DEFAULT_SEL(DEFAULT_SEL), .DIVREF_BIT(DIVREF_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .pwrOkN(pwrOkN), .selCode(selCode),
  .ready(ready), .testMode(testMode), .testDivRef(testDivRef)
);

// File: tb/fsel_latch_tb.sv
`timescale 1ns/1ps
module fsel_latch_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrOkN = 1'b1;
  logic [3:0] selBin = 4'b0000;
  logic [1:0] midLvl = 2'b01;
  logic [5:0] selCode;
  logic       ready, testMode, testDivRef;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [5:0] code;
    logic       rdy;
    logic       tm;
    logic       dr;
    string      tag;
  } exp_t;
  exp_t q[$];

  localparam logic [5:0] DEF = 6'b01_0000;

  always #4 clk = ~clk;

  fsel_latch u_dut (
    .clk(clk), .rstN(rstN), .pwrOkN(pwrOkN), .selBin(selBin), .midLvl(midLvl),
    .selCode(selCode), .ready(ready), .testMode(testMode), .testDivRef(testDivRef)
  );

  // monitor: compares queued expectations at the falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        e = q.pop_front();
        vectors++;
        if (selCode !== e.code || ready !== e.rdy || testMode !== e.tm || testDivRef !== e.dr) begin
          misses++;
          $display("FAIL %s: got code=%b rdy=%b tm=%b dr=%b, exp code=%b rdy=%b tm=%b dr=%b",
                   e.tag, selCode, ready, testMode, testDivRef, e.code, e.rdy, e.tm, e.dr);
        end
      end
    end
  end

  task automatic expectOut(input logic [5:0] c, input logic r, input logic t,
                           input logic d, input string tag);
    exp_t e;
    e.code = c; e.rdy = r; e.tm = t; e.dr = d; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic drive(input logic pg, input logic [3:0] s, input logic [1:0] m);
    @(negedge clk);
    pwrOkN = pg; selBin = s; midLvl = m;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(2);
    expectOut(DEF, 0, 0, 0, "R1 reset");
    @(negedge clk) rstN = 1'b1;
    drive(1, 4'b0101, 2'b00);

    // R3 single-edge glitch
    drive(0, 4'b0101, 2'b00);
    drive(1, 4'b0101, 2'b00);
    step(6);
    expectOut(DEF, 0, 0, 0, "R3 glitch ignored");

    // R2 capture latency
    drive(0, 4'b0101, 2'b00);
    step(3);
    expectOut(DEF, 0, 0, 0, "R2 not before edge 4");
    step(1);
    expectOut(6'b00_0101, 1, 0, 0, "R2 R6 capture normal");

    // R4 / R5 lock
    drive(0, 4'b1010, 2'b10);
    step(5);
    expectOut(6'b00_0101, 1, 0, 0, "R4 straps ignored");
    drive(1, 4'b1010, 2'b10);
    step(5);
    expectOut(6'b00_0101, 1, 0, 0, "R5 pg high ignored");
    drive(0, 4'b1010, 2'b10);
    step(5);
    expectOut(6'b00_0101, 1, 0, 0, "R5 pg low ignored");

    // R10 async reset, then capture into test mode
    @(negedge clk) rstN = 1'b0;
    step(1);
    expectOut(DEF, 0, 0, 0, "R10 R1 reset clears");
    @(negedge clk) rstN = 1'b1;
    step(4);
    expectOut(6'b10_1010, 1, 1, 1, "R10 R6 R7 test capture divref");

    // R8 follow in test mode, tristate behaviour
    drive(0, 4'b1000, 2'b11);
    step(1);
    expectOut(6'b11_1000, 1, 1, 0, "R8 R7 follow tristate");

    // R9 release and recapture
    drive(1, 4'b1000, 2'b11);
    step(3);
    expectOut(DEF, 0, 0, 0, "R9 release");
    drive(0, 4'b0011, 2'b01);
    step(4);
    expectOut(6'b01_0011, 1, 0, 0, "R9 recapture");
    drive(0, 4'b1100, 2'b10);
    step(3);
    expectOut(6'b01_0011, 1, 0, 0, "R4 locked after recapture");

    // R8 leaving test mode through a recapture
    @(negedge clk) begin rstN = 1'b0; pwrOkN = 1'b0; selBin = 4'b0000; midLvl = 2'b10; end
    @(negedge clk) rstN = 1'b1;
    step(4);
    expectOut(6'b10_0000, 1, 1, 0, "R6 test entry");
    drive(0, 4'b0110, 2'b00);
    step(1);
    expectOut(6'b00_0110, 1, 0, 0, "R8 exit test");
    drive(0, 4'b1111, 2'b10);
    step(3);
    expectOut(6'b00_0110, 1, 0, 0, "R4 locked after exit");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule